// File: doc/BRIEF.md
# Host Byte-Lane Mailbox

This block carries data words in both directions between a host that runs on its own clock and a core that runs on an unrelated clock. The host sees each word as a set of byte lanes that it reads and writes one at a time through a small register window: a status register at select 0, then the high, middle and low lanes. The core sees whole words on two valid/ready ports. One port delivers the word the host built. The other port accepts a word that the host will read.

The host builds an outgoing word by writing the high and middle lanes into staging registers. Writing the low lane commits the whole word. The transmit-empty flag then stays clear until the core has taken the word. In the other direction, the core hands over a word. The receive-full flag sets once the word reaches the host side. Reading the low lane acknowledges the word and frees the core to send the next one.

The two clock domains exchange each handoff as a toggle that passes through a two-flop synchronizer, in each direction. The word register stays frozen while its toggle is in flight. The receiving side therefore never samples a word while it is changing.

Four small state machines control the block:
- Host transmit: `TX_FREE` and `TX_BUSY`. A commit moves it from FREE to BUSY. A synchronized acknowledge moves it back.
- Host receive: `RX_VOID` and `RX_HOLD`. A synchronized request moves it from VOID to HOLD. A read of the low lane while holding moves it back.
- Core input: `CI_IDLE` and `CI_OFFER`. A synchronized request moves it from IDLE to OFFER. A handshake with the core moves it back.
- Core output: `CO_IDLE` and `CO_WAIT`. An accepted core word moves it from IDLE to WAIT. A synchronized acknowledge moves it back.

Top module: `mbx_host_mailbox`

## Requirements
- R1: After reset the status register reads transmit-empty = 1 (bit 1) and receive-full = 0 (bit 0), `core_in_valid` is 0 and `core_out_ready` is 1.
- R2: The host select decodes as follows: 0 is the status register, with bit 0 receive-full, bit 1 transmit-empty and the upper bits 0. Select 1 is the high lane (bits 23:16), 2 is the middle lane (bits 15:8) and 3 is the low lane (bits 7:0).
- R3: A write to the low lane while transmit-empty is set commits the word {staged high, staged middle, written byte}. Transmit-empty reads 0 from the next host clock edge.
- R4: A committed word appears on `core_in_data` with `core_in_valid` high. It stays unchanged until a cycle with `core_in_ready` high accepts it, and `core_in_valid` then drops.
- R5: Once the core has accepted the word, transmit-empty sets again after the synchronizer latency.
- R6: Writes to any transmit lane while transmit-empty is clear are ignored. The staged high and middle lanes keep their last accepted values from one word to the next.
- R7: The core passes a word with `core_out_valid`/`core_out_ready`. After a handshake, `core_out_ready` stays low until the host has acknowledged that word.
- R8: After a core word is accepted, receive-full sets after the synchronizer latency, and the three lanes read back that word.
- R9: Reads of the high or middle lane leave receive-full set. A read of the low lane while full clears it at the next host edge and makes `core_out_ready` return.
- R10: A read of the low lane while receive-full is clear has no effect on either flag or on the core side.
- R11: A word register that feeds the other domain does not change while its handoff is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| host_clk | input | 1 | Host domain clock |
| host_rst_n | input | 1 | Host domain asynchronous reset, active low |
| host_sel | input | 2 | Register select: status, high, middle, low |
| host_rd | input | 1 | Read strobe |
| host_wr | input | 1 | Write strobe |
| host_wdata | input | 8 | Write byte |
| host_rdata | output | 8 | Read byte for the selected register |
| core_clk | input | 1 | Core domain clock |
| core_rst_n | input | 1 | Core domain asynchronous reset, active low |
| core_in_valid | output | 1 | Word from the host is available |
| core_in_ready | input | 1 | Core takes the word from the host |
| core_in_data | output | 24 | Word from the host |
| core_out_valid | input | 1 | Core offers a word for the host |
| core_out_ready | output | 1 | Mailbox can accept a core word |
| core_out_data | input | 24 | Word for the host |

## Verification
On every clock the assertions check the following:
- A commit on the low lane clears transmit-empty, and an acknowledging low-lane read clears receive-full.
- An ignored write leaves the transmit word unchanged.
- A word offered to the core holds steady until the core takes it.
- The core-output ready stays low after a handshake.
- Both cross-domain word registers stay frozen while their handoff is pending.

Other properties only the bench's scenarios can show:
- The byte lanes reassemble to the right word values.
- Staged lanes carry over into a later word.
- The flags recover after the synchronizer delay.
- A stray low-lane read leaves a later transfer intact.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
    localparam int BYTE_W_DEF = 8;
    localparam int LANES_DEF  = 3;
    localparam int SYNC_DEF   = 2;

    typedef enum logic { TX_FREE, TX_BUSY }  htx_state_t;
    typedef enum logic { RX_VOID, RX_HOLD }  hrx_state_t;
    typedef enum logic { CI_IDLE, CI_OFFER } cin_state_t;
    typedef enum logic { CO_IDLE, CO_WAIT }  cout_state_t;
endpackage

// File: rtl/mbx_sync.sv
module mbx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/mbx_host_side.sv
module mbx_host_side
    import mbx_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int LANES  = 3,
    parameter int SYNC   = 2,
    localparam int WORD_W = BYTE_W * LANES,
    localparam int SEL_W  = $clog2(LANES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SEL_W-1:0]  sel,
    input  logic              rd,
    input  logic              wr,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] rdata,
    output logic [WORD_W-1:0] tx_word,
    output logic              tx_req_tgl,
    input  logic              tx_ack_tgl,
    input  logic [WORD_W-1:0] rx_word,
    input  logic              rx_req_tgl,
    output logic              rx_ack_tgl,
    output logic              tx_empty,
    output logic              rx_full
);
    localparam logic [SEL_W-1:0] SEL_LOW = SEL_W'(LANES);

    htx_state_t tx_st, tx_nx;
    hrx_state_t rx_st, rx_nx;
    logic [LANES-1:1][BYTE_W-1:0] stage;
    logic ack_s, ack_d, req_s, req_d;
    logic ack_edge, req_edge, commit, release_rx;

    mbx_sync #(.STAGES(SYNC)) u_ack_sync (.clk(clk), .rst_n(rst_n), .d(tx_ack_tgl), .q(ack_s));
    mbx_sync #(.STAGES(SYNC)) u_req_sync (.clk(clk), .rst_n(rst_n), .d(rx_req_tgl), .q(req_s));

    assign ack_edge   = ack_s ^ ack_d;
    assign req_edge   = req_s ^ req_d;
    assign commit     = wr && (sel == SEL_LOW) && (tx_st == TX_FREE);
    assign release_rx = rd && (sel == SEL_LOW) && (rx_st == RX_HOLD);

    // state registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_st <= TX_FREE;
            rx_st <= RX_VOID;
            ack_d <= 1'b0;
            req_d <= 1'b0;
        end else begin
            tx_st <= tx_nx;
            rx_st <= rx_nx;
            ack_d <= ack_s;
            req_d <= req_s;
        end
    end

    always_comb begin
        tx_nx = tx_st;
        unique case (tx_st)
            TX_FREE: if (commit)   tx_nx = TX_BUSY;
            TX_BUSY: if (ack_edge) tx_nx = TX_FREE;
            default: tx_nx = TX_FREE;
        endcase
    end

    always_comb begin
        rx_nx = rx_st;
        unique case (rx_st)
            RX_VOID: if (req_edge)   rx_nx = RX_HOLD;
            RX_HOLD: if (release_rx) rx_nx = RX_VOID;
            default: rx_nx = RX_VOID;
        endcase
    end

    // data and toggles
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage      <= '0;
            tx_word    <= '0;
            tx_req_tgl <= 1'b0;
            rx_ack_tgl <= 1'b0;
        end else begin
            if (wr && (tx_st == TX_FREE)) begin
                for (int k = 1; k < LANES; k++) begin
                    if (sel == SEL_W'(k)) stage[LANES-k] <= wdata;
                end
            end
            if (commit) begin
                tx_word    <= {stage, wdata};
                tx_req_tgl <= ~tx_req_tgl;
            end
            if (release_rx) rx_ack_tgl <= ~rx_ack_tgl;
        end
    end

    // outputs
    always_comb begin
        tx_empty = (tx_st == TX_FREE);
        rx_full  = (rx_st == RX_HOLD);
        rdata    = '0;
        if (sel == '0) begin
            rdata = {{(BYTE_W-2){1'b0}}, tx_empty, rx_full};
        end else begin
            for (int k = 1; k <= LANES; k++) begin
                if (sel == SEL_W'(k)) rdata = rx_word[(LANES-k)*BYTE_W +: BYTE_W];
            end
        end
    end
endmodule

// File: rtl/mbx_core_side.sv
module mbx_core_side
    import mbx_pkg::*;
#(
    parameter int WORD_W = 24,
    parameter int SYNC   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_req_tgl,
    output logic              in_ack_tgl,
    output logic              in_valid,
    input  logic              in_ready,
    input  logic              out_valid,
    output logic              out_ready,
    input  logic [WORD_W-1:0] out_data,
    output logic [WORD_W-1:0] out_word,
    output logic              out_req_tgl,
    input  logic              out_ack_tgl
);
    cin_state_t  ci_st, ci_nx;
    cout_state_t co_st, co_nx;
    logic req_s, req_d, ack_s, ack_d, req_edge, ack_edge, take, load;

    mbx_sync #(.STAGES(SYNC)) u_req_sync (.clk(clk), .rst_n(rst_n), .d(in_req_tgl),  .q(req_s));
    mbx_sync #(.STAGES(SYNC)) u_ack_sync (.clk(clk), .rst_n(rst_n), .d(out_ack_tgl), .q(ack_s));

    assign req_edge = req_s ^ req_d;
    assign ack_edge = ack_s ^ ack_d;
    assign take     = (ci_st == CI_OFFER) && in_ready;
    assign load     = (co_st == CO_IDLE) && out_valid;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ci_st <= CI_IDLE;
            co_st <= CO_IDLE;
            req_d <= 1'b0;
            ack_d <= 1'b0;
        end else begin
            ci_st <= ci_nx;
            co_st <= co_nx;
            req_d <= req_s;
            ack_d <= ack_s;
        end
    end

    always_comb begin
        ci_nx = ci_st;
        unique case (ci_st)
            CI_IDLE:  if (req_edge) ci_nx = CI_OFFER;
            CI_OFFER: if (take)     ci_nx = CI_IDLE;
            default:  ci_nx = CI_IDLE;
        endcase
    end

    always_comb begin
        co_nx = co_st;
        unique case (co_st)
            CO_IDLE: if (load)     co_nx = CO_WAIT;
            CO_WAIT: if (ack_edge) co_nx = CO_IDLE;
            default: co_nx = CO_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            in_ack_tgl  <= 1'b0;
            out_req_tgl <= 1'b0;
            out_word    <= '0;
        end else begin
            if (take) in_ack_tgl <= ~in_ack_tgl;
            if (load) begin
                out_word    <= out_data;
                out_req_tgl <= ~out_req_tgl;
            end
        end
    end

    always_comb begin
        in_valid  = (ci_st == CI_OFFER);
        out_ready = (co_st == CO_IDLE);
    end
endmodule

// File: rtl/mbx_host_mailbox.sv
module mbx_host_mailbox
    import mbx_pkg::*;
#(
    parameter int BYTE_W = BYTE_W_DEF,
    parameter int LANES  = LANES_DEF,
    parameter int SYNC   = SYNC_DEF,
    localparam int WORD_W = BYTE_W * LANES,
    localparam int SEL_W  = $clog2(LANES + 1)
) (
    input  logic              host_clk,
    input  logic              host_rst_n,
    input  logic [SEL_W-1:0]  host_sel,
    input  logic              host_rd,
    input  logic              host_wr,
    input  logic [BYTE_W-1:0] host_wdata,
    output logic [BYTE_W-1:0] host_rdata,
    input  logic              core_clk,
    input  logic              core_rst_n,
    output logic              core_in_valid,
    input  logic              core_in_ready,
    output logic [WORD_W-1:0] core_in_data,
    input  logic              core_out_valid,
    output logic              core_out_ready,
    input  logic [WORD_W-1:0] core_out_data
);
    logic [WORD_W-1:0] tx_word, rx_word;
    logic tx_req_tgl, tx_ack_tgl, rx_req_tgl, rx_ack_tgl;
    logic tx_empty, rx_full;

    mbx_host_side #(.BYTE_W(BYTE_W), .LANES(LANES), .SYNC(SYNC)) u_host (
        .clk(host_clk), .rst_n(host_rst_n),
        .sel(host_sel), .rd(host_rd), .wr(host_wr),
        .wdata(host_wdata), .rdata(host_rdata),
        .tx_word(tx_word), .tx_req_tgl(tx_req_tgl), .tx_ack_tgl(tx_ack_tgl),
        .rx_word(rx_word), .rx_req_tgl(rx_req_tgl), .rx_ack_tgl(rx_ack_tgl),
        .tx_empty(tx_empty), .rx_full(rx_full)
    );

    mbx_core_side #(.WORD_W(WORD_W), .SYNC(SYNC)) u_core (
        .clk(core_clk), .rst_n(core_rst_n),
        .in_req_tgl(tx_req_tgl), .in_ack_tgl(tx_ack_tgl),
        .in_valid(core_in_valid), .in_ready(core_in_ready),
        .out_valid(core_out_valid), .out_ready(core_out_ready),
        .out_data(core_out_data), .out_word(rx_word),
        .out_req_tgl(rx_req_tgl), .out_ack_tgl(rx_ack_tgl)
    );

    // host-built word is held frozen while its handoff is pending
    assign core_in_data = tx_word;
endmodule

// File: rtl/mbx_checker.sv
module mbx_checker #(
    parameter int BYTE_W = 8,
    parameter int LANES  = 3,
    localparam int WORD_W = BYTE_W * LANES,
    localparam int SEL_W  = $clog2(LANES + 1)
) (
    input logic              host_clk,
    input logic              host_rst_n,
    input logic              core_clk,
    input logic              core_rst_n,
    input logic [SEL_W-1:0]  host_sel,
    input logic              host_rd,
    input logic              host_wr,
    input logic              tx_empty,
    input logic              rx_full,
    input logic [WORD_W-1:0] tx_word,
    input logic [WORD_W-1:0] rx_word,
    input logic              core_in_valid,
    input logic              core_in_ready,
    input logic [WORD_W-1:0] core_in_data,
    input logic              core_out_valid,
    input logic              core_out_ready
);
    localparam logic [SEL_W-1:0] LOW = SEL_W'(LANES);

    assert_commit_clears_empty_R3: assert property (@(posedge host_clk) disable iff (!host_rst_n)
        (host_wr && host_sel == LOW && tx_empty) |=> !tx_empty);

    assert_busy_write_ignored_R6: assert property (@(posedge host_clk) disable iff (!host_rst_n)
        (host_wr && !tx_empty) |=> $stable(tx_word));

    assert_low_read_releases_R9: assert property (@(posedge host_clk) disable iff (!host_rst_n)
        (host_rd && host_sel == LOW && rx_full) |=> !rx_full);

    assert_tx_word_frozen_R11: assert property (@(posedge host_clk) disable iff (!host_rst_n)
        (!tx_empty && $past(!tx_empty)) |-> $stable(tx_word));

    assert_offer_held_R4: assert property (@(posedge core_clk) disable iff (!core_rst_n)
        (core_in_valid && !core_in_ready) |=> (core_in_valid && $stable(core_in_data)));

    assert_offer_drops_R4: assert property (@(posedge core_clk) disable iff (!core_rst_n)
        (core_in_valid && core_in_ready) |=> !core_in_valid);

    assert_ready_drops_R7: assert property (@(posedge core_clk) disable iff (!core_rst_n)
        (core_out_valid && core_out_ready) |=> !core_out_ready);

    assert_rx_word_frozen_R11: assert property (@(posedge core_clk) disable iff (!core_rst_n)
        (!core_out_ready && $past(!core_out_ready)) |-> $stable(rx_word));
endmodule

bind mbx_host_mailbox mbx_checker #(.BYTE_W(BYTE_W), .LANES(LANES)) u_chk (
    .host_clk(host_clk), .host_rst_n(host_rst_n),
    .core_clk(core_clk), .core_rst_n(core_rst_n),
    .host_sel(host_sel), .host_rd(host_rd), .host_wr(host_wr),
    .tx_empty(tx_empty), .rx_full(rx_full),
    .tx_word(tx_word), .rx_word(rx_word),
    .core_in_valid(core_in_valid), .core_in_ready(core_in_ready),
    .core_in_data(core_in_data),
    .core_out_valid(core_out_valid), .core_out_ready(core_out_ready)
);

// File: tb/mbx_host_mailbox_test.sv
module mbx_host_mailbox_test;
    logic        hclk = 1'b0, cclk = 1'b0;
    logic        hrst_n = 1'b0, crst_n = 1'b0;
    logic [1:0]  sel = '0;
    logic        rd = 1'b0, wr = 1'b0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic        in_valid, in_ready = 1'b0;
    logic [23:0] in_data;
    logic        out_valid = 1'b0, out_ready;
    logic [23:0] out_data = '0;

    int checks = 0, errors = 0;
    bit done = 1'b0;
    logic [7:0] st_h = '0, st_m = '0;

    always #2 hclk = ~hclk;
    always #3.5 cclk = ~cclk;

    mbx_host_mailbox uut (
        .host_clk(hclk), .host_rst_n(hrst_n), .host_sel(sel),
        .host_rd(rd), .host_wr(wr), .host_wdata(wdata), .host_rdata(rdata),
        .core_clk(cclk), .core_rst_n(crst_n),
        .core_in_valid(in_valid), .core_in_ready(in_ready), .core_in_data(in_data),
        .core_out_valid(out_valid), .core_out_ready(out_ready), .core_out_data(out_data)
    );

    function automatic logic [7:0] status_of(bit empty, bit full);
        return {6'b0, empty, full};
    endfunction

    function automatic logic [23:0] join_word(logic [7:0] h, logic [7:0] m, logic [7:0] l);
        return {h, m, l};
    endfunction

    task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic hwrite(logic [1:0] s, logic [7:0] d);
        @(negedge hclk); sel = s; wdata = d; wr = 1'b1;
        @(negedge hclk); wr = 1'b0;
    endtask

    task automatic hread(logic [1:0] s, output logic [7:0] d);
        @(negedge hclk); sel = s; rd = 1'b1; #0.5 d = rdata;
        @(negedge hclk); rd = 1'b0;
    endtask

    task automatic hpeek(logic [1:0] s, output logic [7:0] d);
        @(negedge hclk); sel = s; #0.5 d = rdata;
    endtask

    task automatic wait_status(int bitpos, bit val, string req);
        logic [7:0] s;
        int n = 0;
        do begin hpeek(2'd0, s); n++; end while (s[bitpos] !== val && n < 60);
        check(s[bitpos] === val, req, s, val);
    endtask

    task automatic core_take(logic [23:0] exp, int hold, string req);
        int n = 0;
        @(negedge cclk);
        while (!in_valid && n < 60) begin @(negedge cclk); n++; end
        check(in_valid === 1'b1, req, in_valid, 1);
        for (int i = 0; i < hold; i++) begin
            @(negedge cclk);
            check(in_valid === 1'b1 && in_data === exp, "R4 hold", in_data, exp);
        end
        check(in_data === exp, req, in_data, exp);
        in_ready = 1'b1;
        @(negedge cclk); in_ready = 1'b0;
        check(in_valid === 1'b0, "R4 drop", in_valid, 0);
    endtask

    task automatic host_send(logic [23:0] w, int hold);
        hwrite(2'd1, w[23:16]); st_h = w[23:16];
        hwrite(2'd2, w[15:8]);  st_m = w[15:8];
        hwrite(2'd3, w[7:0]);
        hpeek(2'd0, rdata_tmp);
        check(rdata_tmp[1] === 1'b0, "R3 empty clears", rdata_tmp, 0);
        core_take(w, hold, "R4 word");
        wait_status(1, 1'b1, "R5 empty returns");
    endtask

    logic [7:0] rdata_tmp;

    task automatic core_send(logic [23:0] w);
        int n = 0;
        @(negedge cclk);
        while (!out_ready && n < 60) begin @(negedge cclk); n++; end
        out_data = w; out_valid = 1'b1;
        @(negedge cclk); out_valid = 1'b0;
        check(out_ready === 1'b0, "R7 ready low", out_ready, 0);
    endtask

    task automatic host_recv(logic [23:0] w);
        logic [7:0] h, m, l;
        wait_status(0, 1'b1, "R8 full sets");
        hread(2'd1, h);
        hread(2'd2, m);
        hpeek(2'd0, rdata_tmp);
        check(rdata_tmp[0] === 1'b1, "R9 high/mid keep full", rdata_tmp, 1);
        check(out_ready === 1'b0, "R7 ready held", out_ready, 0);
        hread(2'd3, l);
        check(join_word(h, m, l) === w, "R8 lanes", join_word(h, m, l), w);
        hpeek(2'd0, rdata_tmp);
        check(rdata_tmp[0] === 1'b0, "R9 low clears full", rdata_tmp, 0);
        repeat (8) @(negedge cclk);
        check(out_ready === 1'b1, "R9 core released", out_ready, 1);
    endtask

    initial begin
        #150000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=running expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] s;
        logic [23:0] w;
        void'($urandom(1234));
        repeat (4) @(negedge cclk);
        hrst_n = 1'b1; crst_n = 1'b1;
        repeat (2) @(negedge hclk);

        // R1 reset state, R2 status layout
        hpeek(2'd0, s);
        check(s === status_of(1, 0), "R1 status", s, status_of(1, 0));
        check(in_valid === 1'b0 && out_ready === 1'b1, "R1 core side",
              {in_valid, out_ready}, 2'b01);
        hpeek(2'd1, s);
        check(s === 8'h00, "R2 rx high after reset", s, 0);

        // R10 stray low read while empty
        hread(2'd3, s);
        hpeek(2'd0, s);
        check(s === status_of(1, 0), "R10 flags unchanged", s, status_of(1, 0));
        repeat (8) @(negedge cclk);
        check(out_ready === 1'b1, "R10 core unaffected", out_ready, 1);

        // directed transmit words
        host_send(24'hA5C3_0F, 0);
        host_send(24'hFFFFFF, 3);
        host_send(24'h000000, 1);

        // R6: writes while busy ignored, staging persists
        hwrite(2'd1, 8'h12); st_h = 8'h12;
        hwrite(2'd2, 8'h34); st_m = 8'h34;
        hwrite(2'd3, 8'h56);
        hwrite(2'd1, 8'hEE);
        hwrite(2'd2, 8'hDD);
        hwrite(2'd3, 8'hCC);
        core_take(24'h123456, 2, "R6 busy writes ignored");
        wait_status(1, 1'b1, "R5 empty returns");
        hwrite(2'd3, 8'h9A);
        core_take(join_word(st_h, st_m, 8'h9A), 0, "R6 staging kept");
        wait_status(1, 1'b1, "R5 empty returns");

        // directed receive words; R2 lane order
        core_send(24'h010203);
        host_recv(24'h010203);
        core_send(24'hFEDCBA);
        host_recv(24'hFEDCBA);

        // R10 again after a completed exchange
        hread(2'd3, s);
        core_send(24'h5A5A5A);
        host_recv(24'h5A5A5A);

        // random traffic in both directions
        for (int i = 0; i < 30; i++) begin
            w = 24'($urandom);
            host_send(w, int'($urandom % 4));
            w = 24'($urandom);
            core_send(w);
            host_recv(w);
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule